// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block lives inside a DDR SDRAM controller and decides when AUTO REFRESH commands go out. An interval timer, sized from the clock frequency parameter, raises one refresh obligation every average refresh interval of 7.8125 us. Owed refreshes accumulate in a debt counter. While the debt is small and the main scheduler reports heavy traffic, the refresh is postponed. Once eight refreshes are owed, the request becomes urgent and the arbiter must stop opening rows and close every bank.

The arbiter answers the request with a grant. A refresh is issued only in a cycle where the request, the grant and the all-banks-idle input are all high. Each issued command pays back exactly one owed refresh. It then opens a tRFC window in which all other commands are blocked and CKE is held high. The address bus of the refresh command is driven to zero.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, request, urgent, issue, block, CKE hold, debt and the error flag are all zero.
- R2: The interval is floor(CLK_MHZ*78125/10000) cycles. The first obligation is counted on clock edge number INTERVAL after reset release, and each later one INTERVAL edges after the previous one.
- R3: The debt rises by one on an interval tick and falls by one on an issued refresh. When both happen in the same cycle, the debt does not change.
- R4: The request is high when the debt is nonzero, no tRFC window is open, and either the busy hint is low or the request is urgent.
- R5: While the debt is below MAX_DEBT (8) and the busy hint is high, the request stays low, so the refresh is deferred.
- R6: The urgent output is high whenever the debt is at least MAX_DEBT (8). The request is then raised even when the busy hint is high.
- R7: The issue strobe is high only in a cycle where request, grant and all-banks-idle are all high. Each strobe retires exactly one owed refresh. A grant while any bank is open issues nothing.
- R8: The block output is high for exactly TRFC_CYC cycles after the issue cycle. During that time no request and no further issue occur.
- R9: The CKE-hold output is high in the issue cycle and through the whole tRFC window, and low otherwise.
- R10: The refresh address output is always zero.
- R11: A tick that arrives when the debt is already MAX_DEBT, with no issue in the same cycle, sets the error flag. The flag then stays set until reset, and the debt stops at MAX_DEBT+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Traffic-busy hint from the main scheduler |
| banks_idle_i | input | 1 | High when every bank is precharged |
| ref_gnt_i | input | 1 | Arbiter grants the refresh slot |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Debt limit reached: stop activates, close all banks |
| ref_issue_o | output | 1 | AUTO REFRESH command issued this cycle |
| ref_addr_o | output | ADDR_W | Address bus value for the refresh command (zero) |
| cmd_block_o | output | 1 | tRFC window open: no other commands allowed |
| cke_hold_o | output | 1 | CKE must be kept high |
| debt_o | output | $clog2(MAX_DEBT+2) | Number of refreshes currently owed |
| debt_err_o | output | 1 | Sticky flag: postponement limit exceeded |

## Verification
The bench targets the exact edge on which the first and later ticks land. An off-by-one interval counter would move the debt one cycle early or late. It also lines up a tick with an issue in the same cycle, which a design that gave one of them priority would turn into a debt step. Further cases check the limit edge: the debt at seven under a busy hint must not be urgent and must raise no request, while at eight a request must appear despite the hint. Finally, the bench holds the grant high through and after each tRFC window while refreshes are still owed. A window that is one cycle short, or a design that issued several owed refreshes at once, would then show the wrong issue count and block length. Overflow into the error flag and its stickiness after payback are checked last.

// File: rtl/refresh_pkg.sv
// Package: shared helpers for the refresh scheduler.
// Assumes an integer clock frequency in MHz.
package refresh_pkg;

    // Cycles in one 7.8125 us average refresh interval, rounded down.
    function automatic int unsigned interval_cycles(input int unsigned clk_mhz);
        int unsigned c;
        c = (clk_mhz * 78125) / 10000;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/rf_interval_timer.sv
// Free-running interval timer: produces a one-cycle tick every PERIOD cycles.
// Assumes PERIOD >= 2. The first tick is seen in cycle PERIOD-1 after reset.
module rf_interval_timer #(
    parameter int unsigned PERIOD = 976
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // R2: a tick is followed by a restart of the count.
    assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rf_debt_counter.sv
// Refresh debt counter: adds one per tick and removes one per issued refresh.
// Assumes retire_i is only raised while the debt is nonzero. The counter
// saturates one above the limit and sets a sticky error flag there.
module rf_debt_counter #(
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned DW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          retire_i,
    output logic [DW-1:0] debt_o,
    output logic          urgent_o,
    output logic          err_o
);
    localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);
    localparam logic [DW-1:0] CEIL  = DW'(MAX_DEBT + 1);

    logic [DW-1:0] debt_q;
    logic          err_q;

    // Update the owed count; a tick and a retire in one cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (tick_i && !retire_i) begin
                if (debt_q != CEIL)
                    debt_q <= debt_q + 1'b1;
                if (debt_q >= LIMIT)
                    err_q <= 1'b1;
            end else if (!tick_i && retire_i && debt_q != '0) begin
                debt_q <= debt_q - 1'b1;
            end
        end
    end

    assign debt_o   = debt_q;
    assign urgent_o = (debt_q >= LIMIT);
    assign err_o    = err_q;

    // R3: a lone tick below the ceiling raises the debt by exactly one.
    assert_debt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !retire_i && debt_q < CEIL) |=> (debt_q == $past(debt_q) + 1'b1));
    // R3: a tick and a retire together leave the debt unchanged.
    assert_debt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && retire_i) |=> $stable(debt_q));
    // R11: the error flag never clears once set.
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/rf_rfc_window.sv
// tRFC window timer: opens on a start pulse and stays open TRFC cycles after it.
// Assumes start_i never arrives while the window is open.
module rf_rfc_window #(
    parameter int unsigned TRFC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic open_o
);
    localparam int unsigned CW = $clog2(TRFC + 1);
    localparam logic [CW-1:0] LOAD = CW'(TRFC);

    logic [CW-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign open_o = (cnt_q != '0);

    // R8: the window opens only in the cycle after a start pulse.
    assert_window_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(start_i));
    // R8: a start pulse always leads to an open window with a full count.
    assert_window_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (open_o && cnt_q == LOAD));
endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler top: tracks owed refreshes, defers them under traffic,
// escalates at the debt limit, issues one refresh per grant with banks idle,
// and blocks commands through each tRFC window.
// Assumes the arbiter raises ref_gnt_i only when it can place a command.
module refresh_sched #(
    parameter int unsigned CLK_MHZ  = 125,
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned TRFC_CYC = 10,
    parameter int unsigned ADDR_W   = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            busy_i,
    input  logic                            banks_idle_i,
    input  logic                            ref_gnt_i,
    output logic                            ref_req_o,
    output logic                            ref_urgent_o,
    output logic                            ref_issue_o,
    output logic [ADDR_W-1:0]               ref_addr_o,
    output logic                            cmd_block_o,
    output logic                            cke_hold_o,
    output logic [$clog2(MAX_DEBT+2)-1:0]   debt_o,
    output logic                            debt_err_o
);
    localparam int unsigned INTERVAL = refresh_pkg::interval_cycles(CLK_MHZ);
    localparam int unsigned DW       = $clog2(MAX_DEBT + 2);

    logic          tick;
    logic          win_open;
    logic          urgent;
    logic [DW-1:0] debt;
    logic          req;
    logic          issue;

    rf_interval_timer #(.PERIOD(INTERVAL)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rf_debt_counter #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .retire_i (issue),
        .debt_o   (debt),
        .urgent_o (urgent),
        .err_o    (debt_err_o)
    );

    rf_rfc_window #(.TRFC(TRFC_CYC)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (issue),
        .open_o  (win_open)
    );

    // Request and issue decision for the current cycle.
    always_comb begin
        req   = (debt != '0) && !win_open && (urgent || !busy_i);
        issue = req && ref_gnt_i && banks_idle_i;
    end

    assign ref_req_o    = req;
    assign ref_urgent_o = urgent;
    assign ref_issue_o  = issue;
    assign ref_addr_o   = '0;
    assign cmd_block_o  = win_open;
    assign cke_hold_o   = issue || win_open;
    assign debt_o       = debt;

    // R8: no refresh goes out while a tRFC window is still open.
    assert_no_issue_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue_o |-> !cmd_block_o);
    // R6: at the limit, outside a window, the request is always raised.
    assert_urgent_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent_o && !cmd_block_o) |-> ref_req_o);
    // R7: an issued refresh pays back one owed refresh unless a tick coincides.
    assert_issue_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issue_o && !tick) |=> (debt_o == $past(debt_o) - 1'b1));
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
    localparam int unsigned CLK_MHZ  = 8;
    localparam int unsigned MAX_DEBT = 8;
    localparam int unsigned TRFC     = 5;
    localparam int unsigned ADDR_W   = 13;
    localparam int INTERVAL = (CLK_MHZ * 78125) / 10000;
    localparam int DW = $clog2(MAX_DEBT + 2);

    logic clk = 1'b0;
    logic rst_n, busy, idle, gnt;
    logic req, urgent, issue, block, cke_hold, err;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0] debt;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    refresh_sched #(.CLK_MHZ(CLK_MHZ), .MAX_DEBT(MAX_DEBT), .TRFC_CYC(TRFC),
                    .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .banks_idle_i(idle),
        .ref_gnt_i(gnt), .ref_req_o(req), .ref_urgent_o(urgent),
        .ref_issue_o(issue), .ref_addr_o(addr), .cmd_block_o(block),
        .cke_hold_o(cke_hold), .debt_o(debt), .debt_err_o(err));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; busy = 1'b0; idle = 1'b1; gnt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 req in reset", int'(req), 0);
        chk("R1 debt in reset", int'(debt), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        wait_edges(1);
        chk("R1 req", int'(req), 0);
        chk("R1 urgent", int'(urgent), 0);
        chk("R1 issue", int'(issue), 0);
        chk("R1 block", int'(block), 0);
        chk("R1 cke_hold", int'(cke_hold), 0);
        chk("R1 err", int'(err), 0);
    endtask

    task automatic t_interval_defer();
        do_reset();
        busy = 1'b1;
        wait_edges(INTERVAL - 1);
        chk("R2 debt before first tick", int'(debt), 0);
        wait_edges(1);
        chk("R2 debt after first tick", int'(debt), 1);
        chk("R5 request deferred while busy", int'(req), 0);
        wait_edges(INTERVAL - 1);
        chk("R2 debt before second tick", int'(debt), 1);
        wait_edges(1);
        chk("R2 debt after second tick", int'(debt), 2);
        busy = 1'b0; #1;
        chk("R4 request when not busy", int'(req), 1);
    endtask

    task automatic t_idle_and_window();
        do_reset();
        wait_edges(INTERVAL);
        gnt = 1'b1; idle = 1'b0; #1;
        chk("R7 no issue with open bank", int'(issue), 0);
        wait_edges(3);
        chk("R7 debt kept with open bank", int'(debt), 1);
        idle = 1'b1; #1;
        chk("R7 issue when idle and granted", int'(issue), 1);
        chk("R9 cke hold in issue cycle", int'(cke_hold), 1);
        chk("R10 address zero", int'(addr), 0);
        wait_edges(1);
        chk("R7 debt retired", int'(debt), 0);
        chk("R8 block after issue", int'(block), 1);
        chk("R8 no request in window", int'(req), 0);
        wait_edges(TRFC - 1);
        chk("R8 block at window end", int'(block), 1);
        chk("R9 cke hold in window", int'(cke_hold), 1);
        wait_edges(1);
        chk("R8 block released", int'(block), 0);
        chk("R9 cke hold released", int'(cke_hold), 0);
        gnt = 1'b0;
    endtask

    task automatic t_tick_and_issue();
        do_reset();
        wait_edges(2 * INTERVAL - 1);
        chk("R3 debt before coincident tick", int'(debt), 1);
        gnt = 1'b1; #1;
        chk("R7 issue on tick cycle", int'(issue), 1);
        wait_edges(1);
        gnt = 1'b0;
        chk("R3 tick and issue cancel", int'(debt), 1);
        chk("R8 window opened", int'(block), 1);
    endtask

    task automatic t_urgent_drain();
        int n;
        do_reset();
        busy = 1'b1;
        wait_edges(7 * INTERVAL);
        chk("R6 debt seven", int'(debt), 7);
        chk("R6 not urgent at seven", int'(urgent), 0);
        chk("R5 deferred at seven", int'(req), 0);
        wait_edges(INTERVAL);
        chk("R6 debt eight", int'(debt), 8);
        chk("R6 urgent at eight", int'(urgent), 1);
        chk("R6 request despite busy", int'(req), 1);
        gnt = 1'b1; #1;
        chk("R7 urgent issue", int'(issue), 1);
        wait_edges(1);
        chk("R7 one retired", int'(debt), 7);
        chk("R8 no issue in window", int'(issue), 0);
        chk("R8 no request with debt in window", int'(req), 0);
        wait_edges(TRFC - 1);
        chk("R8 still no issue", int'(issue), 0);
        wait_edges(1);
        chk("R5 busy defers below limit", int'(req), 0);
        busy = 1'b0;
        n = 0;
        for (int i = 0; i < 7 * (TRFC + 1) + 3; i++) begin
            #1;
            if (issue) n++;
            wait_edges(1);
        end
        gnt = 1'b0;
        chk("R7 one command per owed refresh", n, 7);
        chk("R7 debt drained", int'(debt), 0);
        chk("R11 no error", int'(err), 0);
    endtask

    task automatic t_overflow();
        do_reset();
        busy = 1'b1;
        wait_edges(9 * INTERVAL - 1);
        chk("R11 no error at limit", int'(err), 0);
        chk("R11 debt at limit", int'(debt), 8);
        wait_edges(1);
        chk("R11 error set", int'(err), 1);
        chk("R11 debt one above", int'(debt), 9);
        wait_edges(INTERVAL);
        chk("R11 debt saturates", int'(debt), 9);
        gnt = 1'b1; #1;
        wait_edges(1);
        gnt = 1'b0;
        chk("R11 debt after payback", int'(debt), 8);
        chk("R11 error sticky", int'(err), 1);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_interval_defer();
        t_idle_and_window();
        t_tick_and_issue();
        t_urgent_drain();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule